// File: doc/BRIEF.md
# Lock-Bit Program/Erase Verify Sequencer

This block sits on the host side of a parallel NOR flash bus. It programs one persistent sector-lock bit, or erases the whole set of lock bits, and then confirms the result by reading bit 0 of the data bus. One request starts a complete operation: a pulse on `start` with `op_erase` and `req_addr`. The sequencer then issues all of its bus cycles without further help, including the timed pause, the verify write and the verify read. When the bit reads back wrong it repeats the whole command.

Each pass has six bus cycles. The first three writes go to the fixed low addresses 555h and 2AAh and carry unlock and entry codes. The fourth write is the program or erase command. A timed wait follows. The fifth write is the verify command, and the sixth cycle is a read of DQ0. An erase request first takes every lock bit through a program pass, in ascending order, so that no bit is erased from the unprogrammed state. The final bus cycle always writes the reset code, which returns the flash to array reads. `done` then pulses, and `fail` tells the caller how the operation ended. All opcodes, wait times, retry limits and bus phase lengths are parameters.

Top module: `lockbit_verify_seq`

## Requirements
- R1: While in reset and after it, `busy`, `done` and `fail` are low. `f_we_n`, `f_oe_n` and `f_ce_n` are high, and `f_dq_oe` is low.
- R2: A pass on a lock address A writes these cycles in order:
  - UNLOCK_A (default AAh) at 555h
  - UNLOCK_B (default 55h) at 2AAh
  - ENTRY_OP (default C0h) at 555h
  - the command at A: PROG_OP (default A0h) to program, ERASE_OP (default 80h) to erase
  - VERIFY_OP (default 40h) at A
  - then one read at A.
  Address bits above bit 11 are zero in the 555h/2AAh cycles. Data bits 15..8 are zero in every write.
- R3: In every bus write:
  - address and data are stable for at least one cycle before `f_we_n` falls;
  - `f_ce_n` is low while `f_we_n` is low;
  - `f_oe_n` is never low together with `f_we_n`;
  - the data bus is still driven with the same value in the cycle after `f_we_n` rises.
- R4: The time from the rising `f_we_n` of the command write to the rising `f_we_n` of the verify write is at least the wait length. For a program this is (CLK_FREQ_HZ/1e6)·PROG_WAIT_US cycles; for an erase it is (CLK_FREQ_HZ/1e6)·ERASE_WAIT_US cycles.
- R5: A program pass succeeds when DQ0 reads 1. An erase pass succeeds when DQ0 reads 0.
- R6: When the verify read does not match, the pass is reissued in full, starting again from the first unlock write.
- R7: A lock bit gets at most RETRY_MAX passes. If the last one fails, the operation ends with `fail` high when `done` pulses.
- R8: An erase request first programs and verifies lock index 0 up to NUM_LOCKS-1, at address index<<LOCK_SHIFT. The erase passes follow, at address 0, and are issued only when every lock bit is set.
- R9: The operation ends with one write of RESET_OP (default F0h) at address 0, on success and on failure alike. `done` is then high for exactly one cycle.
- R10: A `start` that arrives while `busy` is high has no effect on the bus cycles or on the result.
- R11: `busy` is high from the cycle after an accepted `start` until `done`, and it is low while `done` is high. `fail` is valid with `done` and is held until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, accepted when idle |
| op_erase | input | 1 | 1: erase all lock bits; 0: program one lock bit |
| req_addr | input | 20 | Lock-bit address for a program request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| fail | output | 1 | Retry limit reached; valid with done |
| f_addr | output | 20 | Flash address |
| f_dq_out | output | 16 | Flash write data |
| f_dq_oe | output | 1 | Host drives the data bus |
| f_dq_in | input | 16 | Flash read data |
| f_we_n | output | 1 | Write enable, active low |
| f_oe_n | output | 1 | Output enable, active low |
| f_ce_n | output | 1 | Chip enable, active low |

## Verification
The assertions check the bus rules on every cycle:
- the strobes never overlap;
- chip enable covers each write pulse;
- address and data stay stable while WE# is low;
- `done` is a single-cycle pulse;
- `busy` behaves correctly around `done`;
- the retry counter stays bounded;
- the request is not re-captured while busy.

Some behaviour only the bench's flash model and scoreboard can show. That covers the exact write order, the reissue after each injected verify mismatch, the program-all pass before erase, the wait between command and verify, the data hold after WE# rises, and the final reset write.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    localparam int BUS_AW = 20;
    localparam int BUS_DW = 16;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } lock_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WAIT,
        ST_VER_W,
        ST_VER_R,
        ST_JUDGE,
        ST_RESET,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_HOLD
    } bus_phase_e;

    typedef enum logic {
        PASS_PREPROG,
        PASS_MAIN
    } pass_kind_e;

    typedef struct packed {
        logic              rd;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] data;
    } bus_req_t;

    function automatic int us_to_cycles(input int clk_hz, input int us);
        return (clk_hz / 1_000_000) * us;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [BUS_DW-1:0] byte_word(input logic [7:0] code);
        return {{(BUS_DW-8){1'b0}}, code};
    endfunction

endpackage

// File: rtl/lbs_wait_timer.sv
module lbs_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] len,
    output logic         fin
);
    logic [W-1:0] cnt;
    logic         run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
            fin <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                cnt <= len;
                run <= 1'b1;
            end else if (run) begin
                cnt <= cnt - 1'b1;
                if (cnt == W'(1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    assert_len_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        start |-> (len != '0));

    assert_no_restart_R4: assert property (@(posedge clk) disable iff (rst)
        start |-> !run);
endmodule

// File: rtl/lbs_bus_engine.sv
module lbs_bus_engine
    import lbs_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 2,
    parameter int HOLD_CYC  = 1,
    parameter int READ_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  bus_req_t          req,
    output logic              done,
    output logic [BUS_DW-1:0] rdata,
    output logic [BUS_AW-1:0] f_addr,
    output logic [BUS_DW-1:0] f_dq_out,
    output logic              f_dq_oe,
    input  logic [BUS_DW-1:0] f_dq_in,
    output logic              f_we_n,
    output logic              f_oe_n,
    output logic              f_ce_n
);
    localparam int CMAX  = max_of(max_of(SETUP_CYC, PULSE_CYC), max_of(HOLD_CYC, READ_CYC));
    localparam int CNT_W = $clog2(CMAX + 1);

    bus_phase_e       phase;
    logic [CNT_W-1:0] cnt;
    logic             is_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            is_rd    <= 1'b0;
            done     <= 1'b0;
            rdata    <= '0;
            f_addr   <= '0;
            f_dq_out <= '0;
            f_dq_oe  <= 1'b0;
            f_we_n   <= 1'b1;
            f_oe_n   <= 1'b1;
            f_ce_n   <= 1'b1;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (go) begin
                        phase  <= PH_SETUP;
                        cnt    <= CNT_W'(SETUP_CYC - 1);
                        is_rd  <= req.rd;
                        f_addr <= req.addr;
                        f_ce_n <= 1'b0;
                        if (!req.rd) begin
                            f_dq_out <= req.data;
                            f_dq_oe  <= 1'b1;
                        end
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_ACTIVE;
                        if (is_rd) begin
                            cnt    <= CNT_W'(READ_CYC - 1);
                            f_oe_n <= 1'b0;
                        end else begin
                            cnt    <= CNT_W'(PULSE_CYC - 1);
                            f_we_n <= 1'b0;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_ACTIVE: begin
                    if (cnt == '0) begin
                        phase  <= PH_HOLD;
                        cnt    <= CNT_W'(HOLD_CYC - 1);
                        f_we_n <= 1'b1;
                        f_oe_n <= 1'b1;
                        if (is_rd) rdata <= f_dq_in;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        phase   <= PH_IDLE;
                        done    <= 1'b1;
                        f_ce_n  <= 1'b1;
                        f_dq_oe <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(!f_we_n && !f_oe_n));

    assert_ce_covers_we_R3: assert property (@(posedge clk) disable iff (rst)
        !f_we_n |-> !f_ce_n);

    assert_we_bus_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !f_we_n |-> ($stable(f_addr) && $stable(f_dq_out) && f_dq_oe));

    assert_go_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        go |-> (phase == PH_IDLE));
endmodule

// File: rtl/lbs_controller.sv
module lbs_controller
    import lbs_pkg::*;
#(
    parameter int         NUM_LOCKS  = 8,
    parameter int         LOCK_SHIFT = 12,
    parameter int         RETRY_MAX  = 4,
    parameter int         WAIT_W     = 16,
    parameter int         PROG_CYC   = 5000,
    parameter int         ERASE_CYC  = 60000,
    parameter logic [7:0] UNLOCK_A   = 8'hAA,
    parameter logic [7:0] UNLOCK_B   = 8'h55,
    parameter logic [7:0] ENTRY_OP   = 8'hC0,
    parameter logic [7:0] PROG_OP    = 8'hA0,
    parameter logic [7:0] ERASE_OP   = 8'h80,
    parameter logic [7:0] VERIFY_OP  = 8'h40,
    parameter logic [7:0] RESET_OP   = 8'hF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  lock_op_e          op,
    input  logic [BUS_AW-1:0] addr,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              eng_go,
    output bus_req_t          eng_req,
    input  logic              eng_done,
    input  logic [BUS_DW-1:0] eng_rdata,
    output logic              tmr_start,
    output logic [WAIT_W-1:0] tmr_len,
    input  logic              tmr_fin
);
    localparam int IDX_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1;
    localparam int TRY_W = $clog2(RETRY_MAX + 1);
    localparam logic [BUS_AW-1:0] ADDR_U1 = BUS_AW'(12'h555);
    localparam logic [BUS_AW-1:0] ADDR_U2 = BUS_AW'(12'h2AA);

    seq_state_e        state;
    pass_kind_e        pass;
    lock_op_e          op_q;
    logic [BUS_AW-1:0] addr_q;
    logic [IDX_W-1:0]  idx;
    logic [1:0]        step;
    logic [TRY_W-1:0]  tries;
    logic              launched;
    logic              rd_bit;
    logic              erase_pass;
    logic              verify_ok;
    logic [BUS_AW-1:0] lock_addr;
    logic [BUS_AW-1:0] preprog_addr;

    generate
        if (NUM_LOCKS > 1) begin : g_multi
            assign preprog_addr = BUS_AW'(idx) << LOCK_SHIFT;
        end else begin : g_single
            assign preprog_addr = '0;
        end
    endgenerate

    assign erase_pass = (pass == PASS_MAIN) && (op_q == OP_ERASE);
    assign lock_addr  = (pass == PASS_PREPROG) ? preprog_addr :
                        (op_q == OP_ERASE)     ? '0 : addr_q;
    assign verify_ok  = (rd_bit == !erase_pass);

    always_comb begin
        eng_req = '{rd: 1'b0, addr: '0, data: '0};
        case (state)
            ST_CMD: begin
                case (step)
                    2'd0:    eng_req = '{rd: 1'b0, addr: ADDR_U1, data: byte_word(UNLOCK_A)};
                    2'd1:    eng_req = '{rd: 1'b0, addr: ADDR_U2, data: byte_word(UNLOCK_B)};
                    2'd2:    eng_req = '{rd: 1'b0, addr: ADDR_U1, data: byte_word(ENTRY_OP)};
                    default: eng_req = '{rd: 1'b0, addr: lock_addr,
                                         data: byte_word(erase_pass ? ERASE_OP : PROG_OP)};
                endcase
            end
            ST_VER_W: eng_req = '{rd: 1'b0, addr: lock_addr, data: byte_word(VERIFY_OP)};
            ST_VER_R: eng_req = '{rd: 1'b1, addr: lock_addr, data: '0};
            ST_RESET: eng_req = '{rd: 1'b0, addr: '0, data: byte_word(RESET_OP)};
            default:  eng_req = '{rd: 1'b0, addr: '0, data: '0};
        endcase
    end

    assign eng_go = !launched && ((state == ST_CMD) || (state == ST_VER_W) ||
                                  (state == ST_VER_R) || (state == ST_RESET));
    assign tmr_start = (state == ST_CMD) && eng_done && (step == 2'd3);
    assign tmr_len   = erase_pass ? WAIT_W'(ERASE_CYC) : WAIT_W'(PROG_CYC);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pass     <= PASS_MAIN;
            op_q     <= OP_PROGRAM;
            addr_q   <= '0;
            idx      <= '0;
            step     <= '0;
            tries    <= '0;
            launched <= 1'b0;
            rd_bit   <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
            fail     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (eng_go)        launched <= 1'b1;
            else if (eng_done) launched <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        op_q   <= op;
                        addr_q <= addr;
                        idx    <= '0;
                        step   <= '0;
                        tries  <= '0;
                        pass   <= (op == OP_ERASE) ? PASS_PREPROG : PASS_MAIN;
                        fail   <= 1'b0;
                        busy   <= 1'b1;
                        state  <= ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (eng_done) begin
                        if (step == 2'd3) state <= ST_WAIT;
                        else              step  <= step + 1'b1;
                    end
                end
                ST_WAIT:  if (tmr_fin)  state <= ST_VER_W;
                ST_VER_W: if (eng_done) state <= ST_VER_R;
                ST_VER_R: begin
                    if (eng_done) begin
                        rd_bit <= eng_rdata[0];
                        state  <= ST_JUDGE;
                    end
                end
                ST_JUDGE: begin
                    step <= '0;
                    if (verify_ok) begin
                        tries <= '0;
                        if (pass == PASS_PREPROG) begin
                            if (idx == IDX_W'(NUM_LOCKS - 1)) pass <= PASS_MAIN;
                            else                              idx  <= idx + 1'b1;
                            state <= ST_CMD;
                        end else begin
                            state <= ST_RESET;
                        end
                    end else if (tries == TRY_W'(RETRY_MAX - 1)) begin
                        fail  <= 1'b1;
                        state <= ST_RESET;
                    end else begin
                        tries <= tries + 1'b1;
                        state <= ST_CMD;
                    end
                end
                ST_RESET: if (eng_done) state <= ST_DONE;
                default: begin
                    done  <= 1'b1;
                    busy  <= 1'b0;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_after_start_R11: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_tries_bound_R7: assert property (@(posedge clk) disable iff (rst)
        tries < TRY_W'(RETRY_MAX));

    assert_ignore_start_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(op_q) && $stable(addr_q)));
endmodule

// File: rtl/lockbit_verify_seq.sv
module lockbit_verify_seq
    import lbs_pkg::*;
#(
    parameter int         CLK_FREQ_HZ   = 50_000_000,
    parameter int         PROG_WAIT_US  = 100,
    parameter int         ERASE_WAIT_US = 1200,
    parameter int         RETRY_MAX     = 4,
    parameter int         NUM_LOCKS     = 8,
    parameter int         LOCK_SHIFT    = 12,
    parameter int         SETUP_CYC     = 1,
    parameter int         PULSE_CYC     = 2,
    parameter int         HOLD_CYC      = 1,
    parameter int         READ_CYC      = 2,
    parameter logic [7:0] UNLOCK_A      = 8'hAA,
    parameter logic [7:0] UNLOCK_B      = 8'h55,
    parameter logic [7:0] ENTRY_OP      = 8'hC0,
    parameter logic [7:0] PROG_OP       = 8'hA0,
    parameter logic [7:0] ERASE_OP      = 8'h80,
    parameter logic [7:0] VERIFY_OP     = 8'h40,
    parameter logic [7:0] RESET_OP      = 8'hF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_erase,
    input  logic [BUS_AW-1:0] req_addr,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [BUS_AW-1:0] f_addr,
    output logic [BUS_DW-1:0] f_dq_out,
    output logic              f_dq_oe,
    input  logic [BUS_DW-1:0] f_dq_in,
    output logic              f_we_n,
    output logic              f_oe_n,
    output logic              f_ce_n
);
    localparam int PROG_CYC  = us_to_cycles(CLK_FREQ_HZ, PROG_WAIT_US);
    localparam int ERASE_CYC = us_to_cycles(CLK_FREQ_HZ, ERASE_WAIT_US);
    localparam int WAIT_W    = $clog2(max_of(PROG_CYC, ERASE_CYC) + 1);

    logic              eng_go;
    bus_req_t          eng_req;
    logic              eng_done;
    logic [BUS_DW-1:0] eng_rdata;
    logic              tmr_start;
    logic [WAIT_W-1:0] tmr_len;
    logic              tmr_fin;

    lbs_controller #(
        .NUM_LOCKS(NUM_LOCKS), .LOCK_SHIFT(LOCK_SHIFT), .RETRY_MAX(RETRY_MAX),
        .WAIT_W(WAIT_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
        .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B), .ENTRY_OP(ENTRY_OP),
        .PROG_OP(PROG_OP), .ERASE_OP(ERASE_OP), .VERIFY_OP(VERIFY_OP),
        .RESET_OP(RESET_OP)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .op(op_erase ? OP_ERASE : OP_PROGRAM), .addr(req_addr),
        .busy(busy), .done(done), .fail(fail),
        .eng_go(eng_go), .eng_req(eng_req), .eng_done(eng_done), .eng_rdata(eng_rdata),
        .tmr_start(tmr_start), .tmr_len(tmr_len), .tmr_fin(tmr_fin)
    );

    lbs_bus_engine #(
        .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
        .HOLD_CYC(HOLD_CYC), .READ_CYC(READ_CYC)
    ) u_bus (
        .clk(clk), .rst(rst), .go(eng_go), .req(eng_req),
        .done(eng_done), .rdata(eng_rdata),
        .f_addr(f_addr), .f_dq_out(f_dq_out), .f_dq_oe(f_dq_oe), .f_dq_in(f_dq_in),
        .f_we_n(f_we_n), .f_oe_n(f_oe_n), .f_ce_n(f_ce_n)
    );

    lbs_wait_timer #(.W(WAIT_W)) u_timer (
        .clk(clk), .rst(rst), .start(tmr_start), .len(tmr_len), .fin(tmr_fin)
    );

    assert_idle_bus_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (f_we_n && f_oe_n));
endmodule

// File: tb/test_lockbit_verify_seq.sv
module test_lockbit_verify_seq;
    localparam int RETRY = 3;
    localparam int PWAIT = 50;
    localparam int EWAIT = 100;
    localparam logic [7:0] C_UA = 8'hAA, C_UB = 8'h55, C_EN = 8'hC0,
                           C_PR = 8'hA0, C_ER = 8'h80, C_VF = 8'h40, C_RS = 8'hF0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op_erase = 1'b0;
    logic [19:0] req_addr = '0;
    logic        busy, done, fail, f_dq_oe, f_we_n, f_oe_n, f_ce_n;
    logic [19:0] f_addr;
    logic [15:0] f_dq_out, f_dq_in;

    always #10 clk = ~clk;

    lockbit_verify_seq #(
        .CLK_FREQ_HZ(50_000_000), .PROG_WAIT_US(1), .ERASE_WAIT_US(2),
        .RETRY_MAX(RETRY), .NUM_LOCKS(4), .LOCK_SHIFT(4),
        .UNLOCK_A(C_UA), .UNLOCK_B(C_UB), .ENTRY_OP(C_EN), .PROG_OP(C_PR),
        .ERASE_OP(C_ER), .VERIFY_OP(C_VF), .RESET_OP(C_RS)
    ) i_lockbit_verify_seq (
        .clk(clk), .rst(rst), .start(start), .op_erase(op_erase), .req_addr(req_addr),
        .busy(busy), .done(done), .fail(fail), .f_addr(f_addr), .f_dq_out(f_dq_out),
        .f_dq_oe(f_dq_oe), .f_dq_in(f_dq_in), .f_we_n(f_we_n), .f_oe_n(f_oe_n),
        .f_ce_n(f_ce_n)
    );

    int n_chk = 0;
    int n_fail = 0;
    int done_cnt = 0;
    int cyc = 0;
    logic [35:0] exp_wr[$];
    bit          exp_res[$];

    // flash model state
    logic [3:0] lock_bits = '0;
    int         pfail[4];
    int         efail = 0;
    int         mst = 0;
    int         t_cmd = 0;
    bit         cmd_erase = 1'b0;

    assign f_dq_in = (!f_oe_n && !f_ce_n) ?
                     ((mst == 5) ? {15'b0, lock_bits[f_addr[5:4]]} : 16'hFFFF) : 16'h0000;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor, scoreboard and flash model, all sampled on the falling edge
    logic        prev_we = 1'b1;
    logic [19:0] prev_addr = '0;
    logic [15:0] prev_dq = '0;
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (prev_we && !f_we_n) begin
                chk(f_addr == prev_addr && f_dq_out == prev_dq, "R3 setup",
                    {f_addr, f_dq_out}, {prev_addr, prev_dq});
                chk(!f_ce_n && f_oe_n, "R3 strobes", {f_ce_n, f_oe_n}, 2'b01);
            end
            if (!prev_we && f_we_n) begin
                logic [35:0] got;
                got = {f_addr, f_dq_out};
                chk(f_dq_oe && !f_ce_n, "R3 hold", {f_dq_oe, f_ce_n}, 2'b10);
                if (exp_wr.size() == 0) begin
                    chk(1'b0, "R10 unexpected write", got, 36'h0);
                end else begin
                    logic [35:0] e;
                    e = exp_wr.pop_front();
                    chk(got == e, "R2/R6/R8/R9 write order", got, e);
                end
                if (f_dq_out[7:0] == C_RS) mst = 0;
                else if (f_addr == 20'h555 && f_dq_out[7:0] == C_UA) mst = 1;
                else case (mst)
                    1: mst = (f_addr == 20'h2AA && f_dq_out[7:0] == C_UB) ? 2 : 0;
                    2: mst = (f_addr == 20'h555 && f_dq_out[7:0] == C_EN) ? 3 : 0;
                    3: begin
                        t_cmd = cyc;
                        if (f_dq_out[7:0] == C_PR) begin
                            cmd_erase = 1'b0;
                            if (pfail[f_addr[5:4]] > 0) begin
                                pfail[f_addr[5:4]]--;
                                lock_bits[f_addr[5:4]] = 1'b0;
                            end else lock_bits[f_addr[5:4]] = 1'b1;
                            mst = 4;
                        end else if (f_dq_out[7:0] == C_ER) begin
                            cmd_erase = 1'b1;
                            chk(lock_bits == 4'hF, "R8 all set before erase", lock_bits, 4'hF);
                            if (efail > 0) efail--;
                            else lock_bits = '0;
                            mst = 4;
                        end else mst = 0;
                    end
                    4: begin
                        chk(cyc - t_cmd >= (cmd_erase ? EWAIT : PWAIT), "R4 wait",
                            cyc - t_cmd, cmd_erase ? EWAIT : PWAIT);
                        mst = (f_dq_out[7:0] == C_VF) ? 5 : 0;
                    end
                    default: mst = 0;
                endcase
            end
            if (done) begin
                chk(!busy, "R11 busy low at done", busy, 0);
                if (exp_res.size() == 0) chk(1'b0, "R10 extra done", 1, 0);
                else begin
                    bit ef;
                    ef = exp_res.pop_front();
                    chk(fail == ef, "R5/R7 result", fail, ef);
                end
                done_cnt++;
            end
        end
        prev_we   = f_we_n;
        prev_addr = f_addr;
        prev_dq   = f_dq_out;
    end

    task automatic push_w(input logic [19:0] a, input logic [7:0] d);
        exp_wr.push_back({a, 8'h00, d});
    endtask

    task automatic push_pass(input logic [19:0] a, input logic [7:0] cmd);
        push_w(20'h555, C_UA);
        push_w(20'h2AA, C_UB);
        push_w(20'h555, C_EN);
        push_w(a, cmd);
        push_w(a, C_VF);
    endtask

    // driver: computes the expected writes and result, then issues the request
    task automatic run_op(input bit erase, input logic [19:0] a,
                          input int p0, input int p1, input int p2, input int p3,
                          input int ef, input bit poke);
        int  pf[4];
        bit  ok;
        int  d0;
        pf[0] = p0; pf[1] = p1; pf[2] = p2; pf[3] = p3;
        for (int i = 0; i < 4; i++) pfail[i] = pf[i];
        efail = ef;
        ok = 1'b1;
        if (!erase) begin
            int n;
            n = (pf[a[5:4]] < RETRY) ? pf[a[5:4]] + 1 : RETRY;
            for (int k = 0; k < n; k++) push_pass(a, C_PR);
            ok = pf[a[5:4]] < RETRY;
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (ok) begin
                    int n;
                    n = (pf[i] < RETRY) ? pf[i] + 1 : RETRY;
                    for (int k = 0; k < n; k++) push_pass(20'(i) << 4, C_PR);
                    ok = pf[i] < RETRY;
                end
            end
            if (ok) begin
                int n;
                n = (ef < RETRY) ? ef + 1 : RETRY;
                for (int k = 0; k < n; k++) push_pass(20'h0, C_ER);
                ok = ef < RETRY;
            end
        end
        push_w(20'h0, C_RS);
        exp_res.push_back(!ok);
        d0 = done_cnt;
        @(negedge clk);
        start = 1'b1; op_erase = erase; req_addr = a;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R11 busy after start", busy, 1);
        if (poke) begin
            repeat (30) @(negedge clk);
            start = 1'b1; op_erase = ~erase; req_addr = 20'h20;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(fail == !ok, "R11 fail held", fail, !ok);
        chk(!busy, "R11 idle after done", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) pfail[i] = 0;
        repeat (5) @(negedge clk);
        chk(!busy && !done && !fail, "R1 status in reset", {busy, done, fail}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(f_we_n && f_oe_n && f_ce_n && !f_dq_oe, "R1 bus idle",
            {f_we_n, f_oe_n, f_ce_n, f_dq_oe}, 4'b1110);
        chk(!busy && !done && !fail, "R1 status idle", {busy, done, fail}, 0);
        run_op(1'b0, 20'h30, 0, 0, 0, 0, 0, 1'b0);   // R5 program first time
        run_op(1'b0, 20'h10, 0, 2, 0, 0, 0, 1'b0);   // R6 two reissues
        run_op(1'b0, 20'h20, 0, 0, 3, 0, 0, 1'b0);   // R7 exhaustion
        run_op(1'b1, 20'h00, 0, 1, 0, 0, 1, 1'b1);   // R8 erase, R10 poke
        run_op(1'b1, 20'h00, 0, 0, 0, 0, 3, 1'b0);   // R7 erase exhausted
        run_op(1'b1, 20'h00, 0, 0, 5, 0, 0, 1'b0);   // R8 preprogram fails, no erase
        repeat (100) @(negedge clk);
        chk(exp_wr.size() == 0, "R9 all writes seen", exp_wr.size(), 0);
        chk(exp_res.size() == 0, "R9 all results seen", exp_res.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule